// File: doc/BRIEF.md
# Interrupt Controller Command-Word Shadow

This block listens to I/O write traffic aimed at a cascaded pair of 8259-style interrupt controllers, a master and a slave. The controllers' own registers cannot be read back safely, so the block keeps copies of the words software programmed into them. For each controller it follows the multi-write initialization sequence, so that it knows which initialization word each data-port write carries. It also decodes command-port writes into the two operation words that matter for restore.

Twelve captured bytes are available through one read-only port. A pointer selects the byte presented on that port, and each read strobe moves the pointer on by one entry. A write strobe on the port sends the pointer back to the first entry. Save-and-restore firmware reads the twelve entries in a fixed order before power is removed. It reprograms the controllers from those values after power returns.

Some bits of the stored words are forced to fixed values. This lets firmware write the stored bytes straight back without producing an unintended command.

Top module: `irqShadowTop`

## Requirements
- R1: After reset the pointer selects entry 0. Every entry reads 00h except the two operation-word-3 entries (5 and 11), which read 08h.
- R2: `rdData` always shows the entry the pointer selects, and each cycle with `rdStb` high moves the pointer on by one. The entry order is master, then slave (slave entries are offset by 6). Within each controller the order is init word 1, 2, 3, 4, operation word 2, operation word 3.
- R3: Reading while the pointer is on entry 11 wraps it to entry 0.
- R4: A cycle with `wrStb` high returns the pointer to entry 0. If `rdStb` is high in the same cycle, `wrStb` wins.
- R5: A snooped write to a controller's command port (base address, even) with data bit 4 set is stored as init word 1 and starts that controller's init sequence. The next write to its data port (base+1) is stored as init word 2.
- R6: Init word 3 is expected after word 2 only when word 1 bit 1 is 0. Init word 4 is expected last only when word 1 bit 0 is 1. Data-port writes outside an init sequence change no entry.
- R7: A stored init word 4 has bits [7:5] cleared.
- R8: A command-port write with bits [4:3] = 00 is stored as operation word 2 with bits [6:3] cleared. Writing back the stored byte, and then the stored byte ORed with C0h, leaves the entry unchanged.
- R9: A command-port write with bits [4:3] = 01 is stored as operation word 3 with bits 7 and 4 cleared and bit 3 set.
- R10: A write sent while `ioWrEn` is low changes no entry. A write to an address outside either controller's two ports also changes no entry. Writes to one controller never change the other controller's entries.
- R11: A snooped write captured in the same cycle as a read returns the old entry value during that read. The new value is visible from the next cycle.
- R12: A new init word 1 in the middle of a sequence restarts the sequence. The next data-port write is then init word 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| ioWrEn | input | 1 | Snooped I/O write valid |
| ioAddr | input | 16 | Snooped I/O write address |
| ioWrData | input | 8 | Snooped I/O write data |
| rdStb | input | 1 | Readback port read strobe, advances the pointer |
| wrStb | input | 1 | Readback port write strobe, clears the pointer |
| rdData | output | 8 | Entry currently selected by the pointer |

## Verification
Two kinds of event can fall in the same cycle. The first is a snooped write that updates an entry while that same entry is being read out. The test holds `ioWrEn` and `rdStb` high together while the pointer is on master init word 2. It then checks that the read returns the old byte and that a later pass returns the new one. The second is a read strobe arriving together with a write strobe. That case is provoked directly, and the test judges it by the next read, which must return entry 0.

// File: rtl/irqShadowPkg.sv
package irqShadowPkg;

  localparam int BYTE_W         = 8;
  localparam int WORDS_PER_CTRL = 6;

  // word slot inside one controller's group of entries
  localparam int SLOT_ICW1 = 0;
  localparam int SLOT_ICW2 = 1;
  localparam int SLOT_ICW3 = 2;
  localparam int SLOT_ICW4 = 3;
  localparam int SLOT_OCW2 = 4;
  localparam int SLOT_OCW3 = 5;

  localparam logic [BYTE_W-1:0] OCW3_RESET = 8'h08;

  typedef enum logic [1:0] {
    INIT_IDLE  = 2'd0,
    INIT_WANT2 = 2'd1,
    INIT_WANT3 = 2'd2,
    INIT_WANT4 = 2'd3
  } initState_e;

  // capture strobes from control to datapath, one bit per word slot
  typedef struct packed {
    logic ocw3;
    logic ocw2;
    logic icw4;
    logic icw3;
    logic icw2;
    logic icw1;
  } wordStb_t;

  function automatic logic [BYTE_W-1:0] fixIcw4(input logic [BYTE_W-1:0] d);
    return d & 8'h1F;
  endfunction

  function automatic logic [BYTE_W-1:0] fixOcw2(input logic [BYTE_W-1:0] d);
    return d & 8'h87;
  endfunction

  function automatic logic [BYTE_W-1:0] fixOcw3(input logic [BYTE_W-1:0] d);
    return (d & 8'h67) | 8'h08;
  endfunction

endpackage

// File: rtl/irqShadowCtrl.sv
module irqShadowCtrl
  import irqShadowPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_CTRL = 2,
  parameter logic [NUM_CTRL*ADDR_W-1:0] CTRL_BASES = {16'h00A0, 16'h0020},
  localparam int ENTRIES = NUM_CTRL * WORDS_PER_CTRL,
  localparam int PTR_W   = $clog2(ENTRIES)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ioWrEn,
  input  logic [ADDR_W-1:0]          ioAddr,
  input  logic [BYTE_W-1:0]          ioWrData,
  input  logic                       rdStb,
  input  logic                       wrStb,
  output wordStb_t [NUM_CTRL-1:0]    stbVec,
  output logic [PTR_W-1:0]           ptrQ
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

  // per-controller decode and init sequence tracking
  for (genvar c = 0; c < NUM_CTRL; c++) begin : gCtrl
    localparam logic [ADDR_W-1:0] BASE = CTRL_BASES[c*ADDR_W +: ADDR_W];

    logic       portHit;
    logic       cmdWr;
    logic       datWr;
    initState_e stQ;
    initState_e stD;
    logic       wantIcw3Q;
    logic       wantIcw4Q;
    wordStb_t   stb;

    assign portHit = ioWrEn && (ioAddr[ADDR_W-1:1] == BASE[ADDR_W-1:1]);
    assign cmdWr   = portHit && !ioAddr[0];
    assign datWr   = portHit && ioAddr[0];

    always_comb begin
      stb = '0;
      stD = stQ;
      if (cmdWr) begin
        if (ioWrData[4]) begin
          stb.icw1 = 1'b1;
          stD      = INIT_WANT2;
        end else if (!ioWrData[3]) begin
          stb.ocw2 = 1'b1;
        end else begin
          stb.ocw3 = 1'b1;
        end
      end else if (datWr) begin
        unique case (stQ)
          INIT_WANT2: begin
            stb.icw2 = 1'b1;
            if (wantIcw3Q)      stD = INIT_WANT3;
            else if (wantIcw4Q) stD = INIT_WANT4;
            else                stD = INIT_IDLE;
          end
          INIT_WANT3: begin
            stb.icw3 = 1'b1;
            stD      = wantIcw4Q ? INIT_WANT4 : INIT_IDLE;
          end
          INIT_WANT4: begin
            stb.icw4 = 1'b1;
            stD      = INIT_IDLE;
          end
          default: stD = INIT_IDLE;  // mask write, not kept
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stQ       <= INIT_IDLE;
        wantIcw3Q <= 1'b0;
        wantIcw4Q <= 1'b0;
      end else begin
        stQ <= stD;
        if (stb.icw1) begin
          wantIcw3Q <= !ioWrData[1];
          wantIcw4Q <= ioWrData[0];
        end
      end
    end

    assign stbVec[c] = stb;
  end

  // readback pointer
  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ <= '0;
    end else if (wrStb) begin
      ptrQ <= '0;
    end else if (rdStb) begin
      ptrQ <= (ptrQ == PTR_LAST) ? '0 : ptrQ + 1'b1;
    end
  end

endmodule

// File: rtl/irqShadowDp.sv
module irqShadowDp
  import irqShadowPkg::*;
#(
  parameter int NUM_CTRL = 2,
  localparam int ENTRIES = NUM_CTRL * WORDS_PER_CTRL,
  localparam int PTR_W   = $clog2(ENTRIES)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic [BYTE_W-1:0]       ioWrData,
  input  wordStb_t [NUM_CTRL-1:0] stbVec,
  input  logic [PTR_W-1:0]        ptrQ,
  output logic [BYTE_W-1:0]       rdData
);

  logic [BYTE_W-1:0] entryQ [ENTRIES];

  for (genvar c = 0; c < NUM_CTRL; c++) begin : gCtrl
    logic [WORDS_PER_CTRL-1:0] slotStb;
    assign slotStb = stbVec[c];

    for (genvar k = 0; k < WORDS_PER_CTRL; k++) begin : gSlot
      localparam int IDX = c * WORDS_PER_CTRL + k;
      logic [BYTE_W-1:0] nextVal;
      logic [BYTE_W-1:0] rstVal;

      if (k == SLOT_ICW4) begin : gIcw4
        assign nextVal = fixIcw4(ioWrData);
        assign rstVal  = '0;
      end else if (k == SLOT_OCW2) begin : gOcw2
        assign nextVal = fixOcw2(ioWrData);
        assign rstVal  = '0;
      end else if (k == SLOT_OCW3) begin : gOcw3
        assign nextVal = fixOcw3(ioWrData);
        assign rstVal  = OCW3_RESET;
      end else begin : gRaw
        assign nextVal = ioWrData;
        assign rstVal  = '0;
      end

      always_ff @(posedge clk) begin
        if (!rstN) begin
          entryQ[IDX] <= rstVal;
        end else if (slotStb[k]) begin
          entryQ[IDX] <= nextVal;
        end
      end
    end
  end

  always_comb begin
    rdData = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (ptrQ == PTR_W'(i)) rdData = entryQ[i];
    end
  end

endmodule

// File: rtl/irqShadowTop.sv
module irqShadowTop
  import irqShadowPkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int NUM_CTRL = 2,
  parameter logic [NUM_CTRL*ADDR_W-1:0] CTRL_BASES = {16'h00A0, 16'h0020}
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ioWrEn,
  input  logic [ADDR_W-1:0] ioAddr,
  input  logic [7:0]        ioWrData,
  input  logic              rdStb,
  input  logic              wrStb,
  output logic [7:0]        rdData
);

  localparam int ENTRIES = NUM_CTRL * WORDS_PER_CTRL;
  localparam int PTR_W   = $clog2(ENTRIES);

  wordStb_t [NUM_CTRL-1:0] stbVec;
  logic [PTR_W-1:0]        ptrQ;

  irqShadowCtrl #(
    .ADDR_W    (ADDR_W),
    .NUM_CTRL  (NUM_CTRL),
    .CTRL_BASES(CTRL_BASES)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .ioWrEn  (ioWrEn),
    .ioAddr  (ioAddr),
    .ioWrData(ioWrData),
    .rdStb   (rdStb),
    .wrStb   (wrStb),
    .stbVec  (stbVec),
    .ptrQ    (ptrQ)
  );

  irqShadowDp #(
    .NUM_CTRL(NUM_CTRL)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .ioWrData(ioWrData),
    .stbVec  (stbVec),
    .ptrQ    (ptrQ),
    .rdData  (rdData)
  );

endmodule

// File: rtl/irqShadowChk.sv
module irqShadowChk
  import irqShadowPkg::*;
#(
  parameter int NUM_CTRL = 2,
  localparam int ENTRIES = NUM_CTRL * WORDS_PER_CTRL,
  localparam int PTR_W   = $clog2(ENTRIES)
) (
  input logic             clk,
  input logic             rstN,
  input logic             rdStb,
  input logic             wrStb,
  input logic [7:0]       rdData,
  input logic [PTR_W-1:0] ptrQ
);

  localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(ENTRIES - 1);

  logic [PTR_W-1:0] ptrNext;
  int               slotNow;
  assign ptrNext = (ptrQ == PTR_LAST) ? '0 : ptrQ + 1'b1;
  assign slotNow = int'(ptrQ) % WORDS_PER_CTRL;

  // R4
  ptr_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    wrStb |=> (ptrQ == '0));

  // R2 R3
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rdStb && !wrStb) |=> (ptrQ == $past(ptrNext)));

  // R2
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rdStb && !wrStb) |=> $stable(ptrQ));

  // R3
  ptr_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    ptrQ <= PTR_LAST);

  // R7
  icw4_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotNow == SLOT_ICW4) |-> (rdData[7:5] == 3'b000));

  // R8
  ocw2_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotNow == SLOT_OCW2) |-> (rdData[6:3] == 4'b0000));

  // R9
  ocw3_bits_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotNow == SLOT_OCW3) |-> (!rdData[7] && !rdData[4] && rdData[3]));

endmodule

bind irqShadowTop irqShadowChk #(.NUM_CTRL(NUM_CTRL)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .rdStb (rdStb),
  .wrStb (wrStb),
  .rdData(rdData),
  .ptrQ  (ptrQ)
);

// File: tb/test_irqShadowTop.sv
`timescale 1ns/1ps
module test_irqShadowTop;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        ioWrEn = 1'b0;
  logic [15:0] ioAddr = '0;
  logic [7:0]  ioWrData = '0;
  logic        rdStb = 1'b0;
  logic        wrStb = 1'b0;
  logic [7:0]  rdData;

  int total = 0;
  int bad   = 0;
  logic [7:0] expv [12];

  always #2.5 clk = ~clk;

  irqShadowTop i_irqShadowTop (
    .clk(clk), .rstN(rstN), .ioWrEn(ioWrEn), .ioAddr(ioAddr),
    .ioWrData(ioWrData), .rdStb(rdStb), .wrStb(wrStb), .rdData(rdData)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic snoopWr(input logic [15:0] a, input logic [7:0] d, input logic en = 1'b1);
    @(negedge clk);
    ioWrEn = en; ioAddr = a; ioWrData = d;
    @(posedge clk); #1;
    ioWrEn = 1'b0;
  endtask

  task automatic readEntry(output logic [7:0] d);
    @(negedge clk);
    rdStb = 1'b1;
    #1 d = rdData;
    @(posedge clk); #1;
    rdStb = 1'b0;
  endtask

  task automatic ptrReset();
    @(negedge clk);
    wrStb = 1'b1;
    @(posedge clk); #1;
    wrStb = 1'b0;
  endtask

  task automatic readAll(input string req);
    logic [7:0] d;
    ptrReset();
    for (int i = 0; i < 12; i++) begin
      readEntry(d);
      check($sformatf("%s entry%0d", req, i), d, expv[i]);
    end
  endtask

  // R1 R2: reset contents in readback order
  task automatic tReset();
    for (int i = 0; i < 12; i++) expv[i] = 8'h00;
    expv[5] = 8'h08; expv[11] = 8'h08;
    check("R1 rdData at entry0", rdData, 8'h00);
    readAll("R1 R2 reset");
  endtask

  // R5 R6 R7: full init on both, then mask writes ignored
  task automatic tFullInit();
    snoopWr(16'h0020, 8'h11); snoopWr(16'h0021, 8'h20);
    snoopWr(16'h0021, 8'h04); snoopWr(16'h0021, 8'hFF);
    snoopWr(16'h0021, 8'h55);
    snoopWr(16'h00A0, 8'h11); snoopWr(16'h00A1, 8'h28);
    snoopWr(16'h00A1, 8'h02); snoopWr(16'h00A1, 8'hE1);
    snoopWr(16'h00A1, 8'hAA);
    expv[0] = 8'h11; expv[1] = 8'h20; expv[2] = 8'h04; expv[3] = 8'h1F;
    expv[6] = 8'h11; expv[7] = 8'h28; expv[8] = 8'h02; expv[9] = 8'h01;
    readAll("R5 R6 R7 full init");
  endtask

  // R6: shortened sequences
  task automatic tShortInit();
    snoopWr(16'h0020, 8'h13); snoopWr(16'h0021, 8'h30);
    snoopWr(16'h0021, 8'hE3);
    expv[0] = 8'h13; expv[1] = 8'h30; expv[3] = 8'h03;
    readAll("R6 no icw3");
    snoopWr(16'h00A0, 8'h12); snoopWr(16'h00A1, 8'h40);
    snoopWr(16'h00A1, 8'h77);
    expv[6] = 8'h12; expv[7] = 8'h40;
    readAll("R6 no icw3 no icw4");
  endtask

  // R8 R9: operation words and restore idempotence
  task automatic tOpWords();
    snoopWr(16'h0020, 8'h67); snoopWr(16'h0020, 8'hEE);
    snoopWr(16'h00A0, 8'hE7); snoopWr(16'h00A0, 8'h6A);
    expv[4] = 8'h07; expv[5] = 8'h6E; expv[10] = 8'h87; expv[11] = 8'h6A;
    readAll("R8 R9 op words");
    snoopWr(16'h00A0, 8'h87); snoopWr(16'h00A0, 8'hC7);
    readAll("R8 restore");
  endtask

  // R3: wrap
  task automatic tWrap();
    logic [7:0] d;
    ptrReset();
    for (int i = 0; i < 12; i++) readEntry(d);
    readEntry(d); check("R3 wrap entry0", d, expv[0]);
    readEntry(d); check("R3 wrap entry1", d, expv[1]);
  endtask

  // R4: pointer clear, and clear beating read
  task automatic tClear();
    logic [7:0] d;
    ptrReset();
    readEntry(d); readEntry(d); readEntry(d);
    ptrReset();
    readEntry(d); check("R4 clear", d, expv[0]);
    readEntry(d);
    @(negedge clk); rdStb = 1'b1; wrStb = 1'b1;
    @(posedge clk); #1; rdStb = 1'b0; wrStb = 1'b0;
    readEntry(d); check("R4 clear wins over read", d, expv[0]);
  endtask

  // R10: ignored writes
  task automatic tIgnored();
    snoopWr(16'h0020, 8'h19, 1'b0);
    snoopWr(16'h0022, 8'h19);
    snoopWr(16'h0120, 8'h04);
    snoopWr(16'h00A2, 8'h1B);
    snoopWr(16'h0021, 8'h3C);
    readAll("R10 ignored writes");
  endtask

  // R11: capture in the read cycle
  task automatic tSameCycle();
    logic [7:0] d;
    ptrReset();
    readEntry(d);
    snoopWr(16'h0020, 8'h11);
    expv[0] = 8'h11;
    @(negedge clk);
    ioWrEn = 1'b1; ioAddr = 16'h0021; ioWrData = 8'h99; rdStb = 1'b1;
    #1 check("R11 old value during read", rdData, expv[1]);
    @(posedge clk); #1;
    ioWrEn = 1'b0; rdStb = 1'b0;
    expv[1] = 8'h99;
    readEntry(d); check("R11 pointer moved on", d, expv[2]);
    snoopWr(16'h0021, 8'h05); snoopWr(16'h0021, 8'h02);
    expv[2] = 8'h05; expv[3] = 8'h02;
    readAll("R11 new value visible");
  endtask

  // R12: restart mid-sequence
  task automatic tRestart();
    snoopWr(16'h0020, 8'h11); snoopWr(16'h0021, 8'h50);
    snoopWr(16'h0020, 8'h13); snoopWr(16'h0021, 8'h60);
    snoopWr(16'h0021, 8'h0F);
    expv[0] = 8'h13; expv[1] = 8'h60; expv[3] = 8'h0F;
    readAll("R12 restart");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tReset();
    tFullInit();
    tShortInit();
    tOpWords();
    tWrap();
    tClear();
    tIgnored();
    tSameCycle();
    tRestart();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule